// File: doc/BRIEF.md
# Ring Node Word Interface

This block is the attachment point of one processing node on a one-way ring that carries one data word per hop. On its local side a processor issues one of three accesses: fetch the word arriving from the upstream neighbour, place a word toward the downstream neighbour, or fetch the upstream word and send the same word on in a single access. The block holds a single receive register and a single send register. Each hop between neighbours uses two flow-control signals: a forward valid and a backward space indication.

The processor sees one wait line, `cpu_ready_o`. It is low only while the requested access cannot finish in the current cycle. Four registers decide it: the node's own receive and send registers, the upstream node's send register (a fetch may take that word directly when the local receive register is empty) and the downstream node's receive register. A word moves from one node's send register into the next node's receive register, or straight to the next processor, on a single clock edge. To broadcast on an N-node ring, every node places its word once, forwards N-2 times and fetches once. It then has received every other node's word in ring order.

Top module: `ring_node`

## Requirements
- R1: After reset both register valid flags are clear: `dn_valid_o` is 0, `up_space_o` is 1 and `cpu_ready_o` is 1.
- R2: A fetch (`cpu_op_i` = 0) waits with `cpu_ready_o` low while neither the receive register nor the upstream send register holds a word. It completes with the oldest available word on `cpu_rdata_o`.
- R3: A place (`cpu_op_i` = 1) waits while the send register is full and the downstream receive register is full. It completes once the downstream node has consumed its word.
- R4: A forward (`cpu_op_i` = 2) returns the upstream word on `cpu_rdata_o` and passes the same word to the downstream node.
- R5: A word placed on a clock edge can be fetched by the downstream processor on the next edge.
- R6: No word is lost, duplicated or reordered on a hop. Under a broadcast with random processor idle time, each node receives the words of nodes i-1, i-2, ..., i-(N-1) in that order.
- R7: With `cpu_req_i` low, `cpu_ready_o` is high whatever the register state. The reserved code `cpu_op_i` = 3 completes at once and changes no register.
- R8: A full send register facing a full downstream receive register holds its valid flag and its data. A full receive register drives `up_space_o` low.
- R9: A forward waits while the send register is full and the downstream receive register is full, even when an upstream word is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Access request, held until ready |
| cpu_op_i | input | 2 | 0 fetch, 1 place, 2 forward, 3 reserved |
| cpu_wdata_i | input | DATA_W | Word to place |
| cpu_rdata_o | output | DATA_W | Fetched or forwarded word |
| cpu_ready_o | output | 1 | High when the access completes this cycle, or when idle |
| up_valid_i | input | 1 | Upstream send register holds a word |
| up_data_i | input | DATA_W | Upstream send register data |
| up_space_o | output | 1 | Receive register is empty |
| dn_valid_o | output | 1 | Send register holds a word |
| dn_data_o | output | DATA_W | Send register data |
| dn_space_i | input | 1 | Downstream receive register is empty |

## Verification
The assertions check on every cycle the stall conditions of fetch, place and forward against the register flags (R2, R3, R9). They also check that ready is high when idle (R7), that a blocked send register keeps its word (R8), and that a held receive word stays put until it is read (R6). Only the bench scenarios can show the ordering across several nodes: that a broadcast delivers every word once, in ring order, under random idle gaps. They also show the one-edge hop latency and that a forwarded word arrives downstream unchanged.

// File: rtl/ring_node_pkg.sv
package ring_node_pkg;
  typedef enum logic [1:0] {
    OP_FETCH   = 2'd0,
    OP_PLACE   = 2'd1,
    OP_FORWARD = 2'd2,
    OP_NOP     = 2'd3
  } ring_op_e;
endpackage

// File: rtl/ring_rx_stage.sv
module ring_rx_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_valid_i,
  input  logic [DATA_W-1:0] up_data_i,
  input  logic              take_i,
  output logic              held_o,
  output logic              avail_o,
  output logic [DATA_W-1:0] word_o
);
  logic              held_q;
  logic [DATA_W-1:0] data_q;
  logic              load;

  // capture only when empty and the word is not bypassed to the processor
  assign load    = !held_q && up_valid_i && !take_i;
  assign held_o  = held_q;
  assign avail_o = held_q || up_valid_i;
  assign word_o  = held_q ? data_q : up_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      data_q <= '0;
    end else if (load) begin
      held_q <= 1'b1;
      data_q <= up_data_i;
    end else if (held_q && take_i) begin
      held_q <= 1'b0;
    end
  end

  assert_rx_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q && !take_i |=> held_q && $stable(data_q));
  assert_rx_take_ok_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> avail_o);
endmodule

// File: rtl/ring_tx_stage.sv
module ring_tx_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              dn_space_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              free_o
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  assign valid_o = valid_q;
  assign data_o  = data_q;
  // slot usable if empty or draining on this edge
  assign free_o  = !valid_q || dn_space_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= load_data_i;
    end else if (dn_space_i) begin
      valid_q <= 1'b0;
    end
  end

  assert_tx_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !dn_space_i |=> valid_q && $stable(data_q));
  assert_tx_no_overwrite_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> free_o);
endmodule

// File: rtl/ring_access_ctl.sv
module ring_access_ctl
  import ring_node_pkg::*;
(
  input  logic       req_i,
  input  logic [1:0] op_i,
  input  logic       avail_i,
  input  logic       out_free_i,
  output logic       ready_o,
  output logic       take_o,
  output logic       load_o,
  output logic       sel_wdata_o
);
  ring_op_e op;
  logic     need_rd, need_wr, ok;

  always_comb begin
    op          = ring_op_e'(op_i);
    need_rd     = (op == OP_FETCH) || (op == OP_FORWARD);
    need_wr     = (op == OP_PLACE) || (op == OP_FORWARD);
    ok          = (!need_rd || avail_i) && (!need_wr || out_free_i);
    ready_o     = !req_i || ok;
    take_o      = req_i && ok && need_rd;
    load_o      = req_i && ok && need_wr;
    sel_wdata_o = (op == OP_PLACE);
  end
endmodule

// File: rtl/ring_node.sv
module ring_node #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic [1:0]        cpu_op_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_ready_o,
  input  logic              up_valid_i,
  input  logic [DATA_W-1:0] up_data_i,
  output logic              up_space_o,
  output logic              dn_valid_o,
  output logic [DATA_W-1:0] dn_data_o,
  input  logic              dn_space_i
);
  logic              take, load, sel_wdata, rx_held, rx_avail, tx_free;
  logic [DATA_W-1:0] rx_word, tx_word;

  ring_rx_stage #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni,
    .up_valid_i, .up_data_i,
    .take_i (take),
    .held_o (rx_held),
    .avail_o(rx_avail),
    .word_o (rx_word)
  );

  assign tx_word = sel_wdata ? cpu_wdata_i : rx_word;

  ring_tx_stage #(.DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni,
    .load_i     (load),
    .load_data_i(tx_word),
    .dn_space_i,
    .valid_o    (dn_valid_o),
    .data_o     (dn_data_o),
    .free_o     (tx_free)
  );

  ring_access_ctl u_ctl (
    .req_i      (cpu_req_i),
    .op_i       (cpu_op_i),
    .avail_i    (rx_avail),
    .out_free_i (tx_free),
    .ready_o    (cpu_ready_o),
    .take_o     (take),
    .load_o     (load),
    .sel_wdata_o(sel_wdata)
  );

  assign up_space_o  = !rx_held;
  assign cpu_rdata_o = rx_word;

  assert_fetch_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_op_i == 2'd0 && up_space_o && !up_valid_i |-> !cpu_ready_o);
  assert_place_wait_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_op_i == 2'd1 && dn_valid_o && !dn_space_i |-> !cpu_ready_o);
  assert_forward_wait_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_op_i == 2'd2 && dn_valid_o && !dn_space_i |-> !cpu_ready_o);
  assert_idle_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_req_i |-> cpu_ready_o);
endmodule

// File: tb/ring_node_bench.sv
module ring_node_bench;
  localparam int DATA_W = 16;
  localparam int NODES  = 4;
  localparam int ROUNDS = 30;
  typedef logic [DATA_W-1:0] word_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       req   [NODES];
  logic [1:0] op    [NODES];
  word_t      wdata [NODES];
  word_t      rdata [NODES];
  logic       ready [NODES];
  logic       dn_valid [NODES];
  word_t      dn_data  [NODES];
  logic       up_space [NODES];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  for (genvar n = 0; n < NODES; n++) begin : g_ring
    localparam int PREV = (n + NODES - 1) % NODES;
    localparam int NEXT = (n + 1) % NODES;
    if (n == 0) begin : g_top
      ring_node #(.DATA_W(DATA_W)) u_ring_node (
        .clk_i(clk), .rst_ni(rst_n),
        .cpu_req_i(req[n]), .cpu_op_i(op[n]), .cpu_wdata_i(wdata[n]),
        .cpu_rdata_o(rdata[n]), .cpu_ready_o(ready[n]),
        .up_valid_i(dn_valid[PREV]), .up_data_i(dn_data[PREV]),
        .up_space_o(up_space[n]),
        .dn_valid_o(dn_valid[n]), .dn_data_o(dn_data[n]),
        .dn_space_i(up_space[NEXT]));
    end else begin : g_peer
      ring_node #(.DATA_W(DATA_W)) u_node (
        .clk_i(clk), .rst_ni(rst_n),
        .cpu_req_i(req[n]), .cpu_op_i(op[n]), .cpu_wdata_i(wdata[n]),
        .cpu_rdata_o(rdata[n]), .cpu_ready_o(ready[n]),
        .up_valid_i(dn_valid[PREV]), .up_data_i(dn_data[PREV]),
        .up_space_o(up_space[n]),
        .dn_valid_o(dn_valid[n]), .dn_data_o(dn_data[n]),
        .dn_space_i(up_space[NEXT]));
    end
  end

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  word_t exp_q [NODES][$];

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // caller is at a falling edge; returns at a falling edge with req low
  task automatic op_run(input int n, input logic [1:0] code, input word_t wd,
                        output word_t rd, output int waits, output int done);
    req[n] = 1'b1; op[n] = code; wdata[n] = wd; waits = 0;
    forever begin
      #1;
      if (ready[n]) break;
      @(negedge clk);
      waits++;
    end
    rd = rdata[n];
    @(posedge clk); #1; done = cyc;
    @(negedge clk);
    req[n] = 1'b0;
  endtask

  // scoreboard consumer: pops the expected word and compares
  task automatic recv(input int n, input logic [1:0] code, input string tag);
    word_t rd, e; int w, d;
    op_run(n, code, '0, rd, w, d);
    e = exp_q[n].pop_front();
    check(rd == e, tag, rd, e);
  endtask

  task automatic idle_gap();
    repeat ($urandom_range(0, 3)) @(negedge clk);
  endtask

  initial begin
    word_t rd, rd2; int w0, w1, d0, d1;
    for (int n = 0; n < NODES; n++) begin
      req[n] = 1'b0; op[n] = 2'd0; wdata[n] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int n = 0; n < NODES; n++) begin
      check(ready[n] == 1'b1,    "R1 ready", ready[n], 1);
      check(dn_valid[n] == 1'b0, "R1 dn_valid", dn_valid[n], 0);
      check(up_space[n] == 1'b1, "R1 up_space", up_space[n], 1);
    end

    // R7 reserved code completes at once with no effect
    op_run(0, 2'd3, 16'hdead, rd, w0, d0);
    check(w0 == 0, "R7 nop waits", w0, 0);
    #1 check(dn_valid[0] == 1'b0, "R7 nop no word", dn_valid[0], 0);

    // R2 fetch on empty ring waits; R5 one-edge hop
    fork
      op_run(1, 2'd0, '0, rd, w1, d1);
      begin
        repeat (3) @(negedge clk);
        op_run(0, 2'd1, 16'h00a1, rd2, w0, d0);
      end
    join
    check(rd == 16'h00a1, "R2 fetch data", rd, 16'h00a1);
    check(w1 >= 3, "R2 fetch stalled", w1, 3);
    check(d1 == d0 + 1, "R5 hop latency", d1 - d0, 1);

    // R3 place blocked by full downstream; R8 hold; R7 idle ready
    op_run(2, 2'd1, 16'h00b1, rd, w0, d0);
    op_run(2, 2'd1, 16'h00b2, rd, w0, d0);
    check(w0 == 0, "R3 place while draining", w0, 0);
    exp_q[3].push_back(16'h00b1);
    exp_q[3].push_back(16'h00b2);
    exp_q[3].push_back(16'h00b3);
    fork
      begin
        op_run(2, 2'd1, 16'h00b3, rd, w0, d0);
        check(w0 >= 2, "R3 place stalled", w0, 2);
      end
      begin
        repeat (2) @(negedge clk);
        #2;
        check(ready[2] == 1'b0,    "R3 ready low", ready[2], 0);
        check(dn_valid[2] == 1'b1, "R8 valid held", dn_valid[2], 1);
        check(dn_data[2] == 16'h00b2, "R8 data held", dn_data[2], 16'h00b2);
        check(up_space[3] == 1'b0, "R8 space low", up_space[3], 0);
        check(ready[3] == 1'b1,    "R7 idle ready", ready[3], 1);
        @(negedge clk);
        recv(3, 2'd0, "R6 order b1");
        recv(3, 2'd0, "R6 order b2");
        recv(3, 2'd0, "R6 order b3");
      end
    join

    // R4 forward passes the same word on
    op_run(0, 2'd1, 16'h00c1, rd, w0, d0);
    op_run(1, 2'd2, '0, rd, w0, d0);
    check(rd == 16'h00c1, "R4 forward data", rd, 16'h00c1);
    op_run(2, 2'd0, '0, rd, w0, d0);
    check(rd == 16'h00c1, "R4 forwarded arrives", rd, 16'h00c1);

    // R9 forward blocked by full send path
    op_run(1, 2'd1, 16'h00e1, rd, w0, d0);
    op_run(1, 2'd1, 16'h00e2, rd, w0, d0);
    op_run(0, 2'd1, 16'h00e0, rd, w0, d0);
    exp_q[2].push_back(16'h00e1);
    exp_q[2].push_back(16'h00e2);
    exp_q[2].push_back(16'h00e0);
    fork
      begin
        op_run(1, 2'd2, '0, rd2, w1, d1);
        check(rd2 == 16'h00e0, "R9 forward data", rd2, 16'h00e0);
        check(w1 >= 2, "R9 forward stalled", w1, 2);
      end
      begin
        repeat (2) @(negedge clk);
        #2 check(ready[1] == 1'b0, "R9 ready low", ready[1], 0);
        @(negedge clk);
        recv(2, 2'd0, "R9 drain e1");
        recv(2, 2'd0, "R9 drain e2");
        recv(2, 2'd0, "R9 drain e0");
      end
    join

    // R6 broadcast rounds with random idle gaps
    for (int r = 0; r < ROUNDS; r++) begin
      for (int n = 0; n < NODES; n++)
        for (int k = 1; k < NODES; k++)
          exp_q[n].push_back({8'(r), 8'((n + NODES - k) % NODES)});
      for (int n = 0; n < NODES; n++) begin
        fork
          automatic int nn = n;
          automatic int rr = r;
          begin
            word_t x; int a, b;
            idle_gap();
            op_run(nn, 2'd1, {8'(rr), 8'(nn)}, x, a, b);
            for (int k = 0; k < NODES - 2; k++) begin
              idle_gap();
              recv(nn, 2'd2, "R6 broadcast forward");
            end
            idle_gap();
            recv(nn, 2'd0, "R6 broadcast fetch");
          end
        join_none
      end
      wait fork;
      @(negedge clk);
    end
    #1;
    for (int n = 0; n < NODES; n++) begin
      check(dn_valid[n] == 1'b0, "R6 ring empty", dn_valid[n], 0);
      check(up_space[n] == 1'b1, "R6 rx empty", up_space[n], 1);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule